// File: doc/BRIEF.md
# PLL Output Frequency Ramp Sequencer

This block controls how a PLL output climbs to its full frequency. When the PLL leaves the bypass clock for its normal output, on lock or on re-lock, the sequencer can hold the output at reduced rates for a while instead of jumping to full speed. It steps a divider-select code through a few fixed stages, waits a programmed number of reference-clock ticks at each stage, and then settles on full frequency. The divider datapath uses the same code for both the normal output and the double-rate output.

A 2-bit level input either disables the ramp or picks one of two divisor sequences. A 3-bit rate input sets how long each stage lasts. Both inputs are captured when a ramp starts and are held until it ends. The lock qualifier stays low until the full-frequency stage is reached, and a one-cycle done pulse marks that moment. Dropping the lock request sends the sequencer back to bypass at once.

Top module: `pll_ramp_seq`

## Requirements
- R1: Out of reset, and one clock after `lock_req` is sampled low, `div_sel` is 0 (bypass), `lock_ok` is 0 and `ramp_done` is 0.
- R2: With level code 1, the `div_sel` codes after a start are 1 (divide by 8), then 2 (divide by 4), then 3 (divide by 2), then 5 (full).
- R3: With level code 2, the `div_sel` codes after a start are 2 (divide by 4), then 3 (divide by 2), then 4 (divide by 1.5), then 5 (full).
- R4: Level code 0 and level code 3 both disable ramping. `div_sel` becomes 5 one clock after the start edge.
- R5: Each reduced stage lasts D accepted ticks. A tick is accepted only on a clock where `ref_tick` is high. D is 2^(c+1) for rate code c from 0 to 6, and D is 512 for code 7. The stage changes on the clock edge that accepts its D-th tick.
- R6: The level and rate values are captured on the start edge. Changes to `ramp_level` or `ramp_rate` during a ramp, or in the full stage, have no effect.
- R7: `ramp_done` is high for exactly the first cycle of the full stage. `lock_ok` is high only while `div_sel` is 5.
- R8: If `lock_req` drops during a ramp, the sequencer goes to bypass on the next clock and clears its tick count. The next ramp therefore gives its first stage the full dwell.
- R9: A ramp starts only when `lock_req` is high while in bypass. While `lock_req` stays high, the full stage holds regardless of ticks or field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_req | input | 1 | High when the PLL is to run on its normal output (lock or re-lock) |
| ref_tick | input | 1 | One-cycle enable, one pulse for each reference-clock period |
| ramp_level | input | 2 | Ramp algorithm: 0 or 3 none, 1 divide 8/4/2, 2 divide 4/2/1.5 |
| ramp_rate | input | 3 | Dwell per stage: 2^(c+1) ticks, code 7 gives 512 |
| div_sel | output | 3 | Divider code: 0 bypass, 1 /8, 2 /4, 3 /2, 4 /1.5, 5 full |
| lock_ok | output | 1 | Lock-indicator qualifier, high in the full stage only |
| ramp_done | output | 1 | One-cycle pulse when the full stage is entered |

## Verification
All outputs are registered, so every result appears one clock edge after the stimulus that causes it. A start shows up one edge after `lock_req` rises. A stage change shows up at the edge that accepts the D-th tick. A drop to bypass shows up one edge after `lock_req` falls. The bench drives inputs on the falling edge and samples on the next falling edge. It keeps a tick count built from the requirements and derives the expected stage from that count, so the same check holds for dense and sparse tick patterns. During each ramp the bench drives altered level and rate values, which checks that the captured values are held.

// File: rtl/pll_ramp_pkg.sv
// Package: pll_ramp_pkg
// Holds the types shared by the ramp sequencer modules: the divider code
// put out to the clock datapath, and the sequencer state.
// Assumes three reduced stages ahead of the full-frequency stage.
package pll_ramp_pkg;

    localparam int NSTAGE = 3;
    localparam int IDX_W  = $clog2(NSTAGE);

    typedef enum logic [2:0] {
        DIV_BYPASS = 3'd0,
        DIV_8      = 3'd1,
        DIV_4      = 3'd2,
        DIV_2      = 3'd3,
        DIV_1P5    = 3'd4,
        DIV_FULL   = 3'd5
    } div_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_FULL = 2'd2
    } ramp_st_e;

endpackage

// File: rtl/ramp_dwell_timer.sv
// Module: ramp_dwell_timer
// Counts accepted reference ticks within one ramp stage and flags the tick
// that ends the stage. Dwell is 2^(c+1) ticks for codes below the top code,
// and the top code doubles the last step (512 for a 3-bit code).
// Assumes rate_sel stays stable while run is high (the FSM holds it).
module ramp_dwell_timer #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              expire
);
    localparam int NCODE = 1 << RATE_W;
    localparam int MAXD  = 1 << (NCODE + 1);
    localparam int CNT_W = $clog2(MAXD);

    logic [CNT_W-1:0] term_tab [NCODE];
    logic [CNT_W-1:0] cnt_q;

    // Build the terminal count (dwell minus one) for each rate code.
    for (genvar g = 0; g < NCODE; g++) begin : g_term
        localparam int DWELL = (g == NCODE - 1) ? (1 << (g + 2)) : (1 << (g + 1));
        assign term_tab[g] = CNT_W'(DWELL - 1);
    end

    // Flag the accepted tick that completes the current stage.
    always_comb begin
        expire = run && tick && (cnt_q == term_tab[rate_sel]);
    end

    // Advance on accepted ticks; wrap at stage end; clear outside a ramp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || expire) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= term_tab[rate_sel]));

    // R8
    cnt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/ramp_stage_fsm.sv
// Module: ramp_stage_fsm
// Sequences bypass, the reduced stages and the full stage. It captures the
// level and rate fields on the start edge and holds them for the whole ramp.
// Assumes lock_req low means bypass; a low lock_req overrides every state.
module ramp_stage_fsm
    import pll_ramp_pkg::*;
#(
    parameter int LEVEL_W = 2,
    parameter int RATE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_req,
    input  logic [LEVEL_W-1:0] level_in,
    input  logic [RATE_W-1:0]  rate_in,
    input  logic               expire,
    output ramp_st_e           st_q,
    output logic [IDX_W-1:0]   idx_q,
    output logic [LEVEL_W-1:0] lvl_q,
    output logic [RATE_W-1:0]  rate_q,
    output logic               run,
    output logic               clear,
    output logic               done_q
);
    logic ramp_en;

    // Decide whether the requested level has a ramp (codes 1 and 2 only).
    always_comb begin
        ramp_en = (level_in == LEVEL_W'(1)) || (level_in == LEVEL_W'(2));
    end

    // Tell the timer when to count and when to drop its count.
    always_comb begin
        run   = (st_q == ST_RAMP);
        clear = !lock_req || (st_q != ST_RAMP);
    end

    // Main state, stage index, captured fields and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            lvl_q  <= '0;
            rate_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!lock_req) begin
                st_q  <= ST_IDLE;
                idx_q <= '0;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        lvl_q  <= level_in;
                        rate_q <= rate_in;
                        idx_q  <= '0;
                        if (ramp_en) begin
                            st_q <= ST_RAMP;
                        end else begin
                            st_q   <= ST_FULL;
                            done_q <= 1'b1;
                        end
                    end
                    ST_RAMP: begin
                        if (expire) begin
                            if (idx_q == IDX_W'(NSTAGE - 1)) begin
                                st_q   <= ST_FULL;
                                done_q <= 1'b1;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_FULL: begin
                        st_q <= ST_FULL;
                    end
                    default: begin
                        st_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R5
    stage_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RAMP && lock_req && !expire) |=> (st_q == ST_RAMP && $stable(idx_q)));

    // R6
    held_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && lock_req) |=> ($stable(lvl_q) && $stable(rate_q)));

    // R9
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FULL && lock_req) |=> (st_q == ST_FULL));

endmodule

// File: rtl/ramp_div_map.sv
// Module: ramp_div_map
// Turns the sequencer state, the stage index and the captured level into
// the divider code. Level 1 runs /8,/4,/2 and level 2 runs /4,/2,/1.5.
// Assumes the index stays below NSTAGE while ramping.
module ramp_div_map
    import pll_ramp_pkg::*;
#(
    parameter int LEVEL_W = 2
) (
    input  ramp_st_e           st,
    input  logic [IDX_W-1:0]   idx,
    input  logic [LEVEL_W-1:0] lvl,
    output div_code_e          code
);
    // Select the divider code for the current stage.
    always_comb begin
        code = DIV_BYPASS;
        case (st)
            ST_FULL: code = DIV_FULL;
            ST_RAMP: begin
                if (lvl == LEVEL_W'(2)) begin
                    case (idx)
                        IDX_W'(0): code = DIV_4;
                        IDX_W'(1): code = DIV_2;
                        IDX_W'(2): code = DIV_1P5;
                        default:   code = DIV_BYPASS;
                    endcase
                end else begin
                    case (idx)
                        IDX_W'(0): code = DIV_8;
                        IDX_W'(1): code = DIV_4;
                        IDX_W'(2): code = DIV_2;
                        default:   code = DIV_BYPASS;
                    endcase
                end
            end
            default: code = DIV_BYPASS;
        endcase
    end
endmodule

// File: rtl/pll_ramp_seq.sv
// Module: pll_ramp_seq
// Top of the PLL output ramp sequencer. It ties the stage FSM, the dwell
// timer and the divider-code map together and registers the outputs.
// Assumes ref_tick is a one-cycle enable in the clk domain.
module pll_ramp_seq
    import pll_ramp_pkg::*;
#(
    parameter int LEVEL_W = 2,
    parameter int RATE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_req,
    input  logic               ref_tick,
    input  logic [LEVEL_W-1:0] ramp_level,
    input  logic [RATE_W-1:0]  ramp_rate,
    output logic [2:0]         div_sel,
    output logic               lock_ok,
    output logic               ramp_done
);
    ramp_st_e           st;
    logic [IDX_W-1:0]   idx;
    logic [LEVEL_W-1:0] lvl;
    logic [RATE_W-1:0]  rate;
    logic               run;
    logic               clear;
    logic               expire;
    logic               done;
    div_code_e          code;

    ramp_stage_fsm #(.LEVEL_W(LEVEL_W), .RATE_W(RATE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .level_in (ramp_level),
        .rate_in  (ramp_rate),
        .expire   (expire),
        .st_q     (st),
        .idx_q    (idx),
        .lvl_q    (lvl),
        .rate_q   (rate),
        .run      (run),
        .clear    (clear),
        .done_q   (done)
    );

    ramp_dwell_timer #(.RATE_W(RATE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .run      (run),
        .tick     (ref_tick),
        .rate_sel (rate),
        .expire   (expire)
    );

    ramp_div_map #(.LEVEL_W(LEVEL_W)) u_map (
        .st   (st),
        .idx  (idx),
        .lvl  (lvl),
        .code (code)
    );

    // Drive the outputs from the registered state.
    always_comb begin
        div_sel   = code;
        lock_ok   = (st == ST_FULL);
        ramp_done = done;
    end

    // R1
    bypass_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_req |=> (div_sel == 3'(DIV_BYPASS) && !lock_ok));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |=> !ramp_done);

    // R7
    done_with_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (lock_ok && div_sel == 3'(DIV_FULL)));

    // R7
    lock_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> (div_sel == 3'(DIV_FULL)));

endmodule

// File: tb/tb_pll_ramp_seq.sv
// Bench: tb_pll_ramp_seq
// Directed scenarios, one task each. Inputs are driven on the falling edge
// and outputs are sampled on the next falling edge.
module tb_pll_ramp_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lock_req;
    logic       ref_tick;
    logic [1:0] ramp_level;
    logic [2:0] ramp_rate;
    logic [2:0] div_sel;
    logic       lock_ok;
    logic       ramp_done;

    int checks = 0;
    int errors = 0;

    pll_ramp_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_req   (lock_req),
        .ref_tick   (ref_tick),
        .ramp_level (ramp_level),
        .ramp_rate  (ramp_rate),
        .div_sel    (div_sel),
        .lock_ok    (lock_ok),
        .ramp_done  (ramp_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input int lvl, input int stage);
        if (stage >= 3) return 5;
        if (lvl == 2) return stage + 2;
        return stage + 1;
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0; lock_req = 1'b0; ref_tick = 1'b0;
        ramp_level = 2'd0; ramp_rate = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(div_sel == 3'd0, "R1 reset div_sel", div_sel, 0);
        chk(lock_ok == 1'b0, "R1 reset lock_ok", lock_ok, 0);
        chk(ramp_done == 1'b0, "R1 reset ramp_done", ramp_done, 0);
    endtask

    // R1: drop lock request and see bypass one edge later
    task automatic t_drop(input string tag);
        lock_req = 1'b0; ref_tick = 1'b0;
        @(negedge clk);
        chk(div_sel == 3'd0, tag, div_sel, 0);
        chk(lock_ok == 1'b0, tag, lock_ok, 0);
        chk(ramp_done == 1'b0, tag, ramp_done, 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R9: one full ramp. Ticks come every per cycles and
    // the fields are inverted right after the start edge.
    task automatic run_ramp(input int lvl, input int rate, input int per, input string tag);
        int d;
        int n;
        int stage;
        int prev;
        int extra;
        int phase;
        int guard;
        bit ramp;
        d = (rate == 7) ? 512 : (2 << rate);
        ramp = (lvl == 1) || (lvl == 2);
        n = 0; prev = -1; extra = 0; phase = 0; guard = 0;
        lock_req = 1'b1; ramp_level = 2'(lvl); ramp_rate = 3'(rate); ref_tick = 1'b0;
        @(posedge clk);
        #1;
        ramp_level = ~2'(lvl);   // R6: must be ignored
        ramp_rate  = ~3'(rate);
        while (extra < 5 && guard < 20000) begin
            @(negedge clk);
            guard++;
            stage = ramp ? ((n / d) > 3 ? 3 : (n / d)) : 3;
            chk(div_sel == 3'(exp_code(lvl, stage)), {tag, " div_sel"}, div_sel, exp_code(lvl, stage));
            chk(lock_ok == (stage == 3), {tag, " R7 lock_ok"}, lock_ok, int'(stage == 3));
            chk(ramp_done == (stage == 3 && prev != 3), {tag, " R7 ramp_done"}, ramp_done,
                int'(stage == 3 && prev != 3));
            prev = stage;
            if (stage == 3) extra++;
            ref_tick = ((phase % per) == 0);
            phase++;
            if (ref_tick) n++;
        end
        chk(guard < 20000, {tag, " ramp finished"}, guard, 0);
    endtask

    // R8: abort in mid-ramp, then a fresh ramp must give its first stage the full dwell
    task automatic t_abort();
        lock_req = 1'b1; ramp_level = 2'd1; ramp_rate = 3'd1; ref_tick = 1'b0;
        @(posedge clk);
        repeat (6) begin
            @(negedge clk);
            ref_tick = 1'b1;
        end
        @(negedge clk);
        chk(div_sel == 3'd2, "R8 mid-ramp stage", div_sel, 2);
        lock_req = 1'b0;
        @(negedge clk);
        chk(div_sel == 3'd0, "R8 abort div_sel", div_sel, 0);
        chk(lock_ok == 1'b0, "R8 abort lock_ok", lock_ok, 0);
        ref_tick = 1'b0;
        @(negedge clk);
        run_ramp(1, 1, 1, "R8 R2 after abort");
        t_drop("R1 after abort ramp");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            run_ramp(1, r, 1, "R2 R5 R6 R9");
            t_drop("R1 drop after full");
        end
        run_ramp(2, 0, 1, "R3 R5 R6");
        t_drop("R1 drop level2");
        run_ramp(2, 7, 1, "R3 R5 rate7");
        t_drop("R1 drop level2 rate7");
        run_ramp(2, 1, 3, "R3 R5 sparse ticks");
        t_drop("R1 drop sparse");
        run_ramp(0, 4, 1, "R4 level0");
        t_drop("R1 drop level0");
        run_ramp(3, 2, 1, "R4 level3");
        t_drop("R1 drop level3");
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule